// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a general-purpose I/O controller for 64 pins, grouped into two banks of 32. Software reaches it over a plain memory-mapped register port: address, write strobe, write data and read data. For each pin there is a direction bit, an output latch and a readable level. Rising-edge and falling-edge detection can be enabled independently, and a detected edge is latched into a sticky status register.

The output latch has no data register that software rewrites. It changes only through two strobe registers. Writing ones to the set register drives the chosen pins high, and writing ones to the clear register drives them low, so two agents that touch different pins never need a read-modify-write. Pin inputs pass through a two-flop synchroniser before they are read back or checked for edges. When a pin is an output, the synchroniser sees the driven value instead of the pad input. Every detected edge stays recorded until software writes a one to that status bit, and any recorded edge raises the single shared interrupt line.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: While reset is active, and immediately after it, the direction, output latch, both edge enables and the status register are all zero. `pinOut`, `pinOe` and `irq` are low, and every register reads back zero.
- R2: The register at byte offset `(kind*2 + bank)*4` has these kinds: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status. Bank 0 is the lower word of each pair, and pin n sits in bank n/32 at bit n%32. Offsets 0x38 and 0x3C read zero, and writes to them change nothing.
- R3: Writing a one to a bit of the set register makes that pin's `pinOut` high after the write edge. Writing a one to the clear register makes it low. A zero bit in either write leaves the pin unchanged. Both strobe registers read zero.
- R4: The direction register is read/write and holds its value. `pinOe[n]` equals direction bit n, where 1 means output and 0 means input.
- R5: For an input pin, the level register returns `pinIn` as it was two rising edges earlier, after the two-flop synchroniser.
- R6: For an output pin, the level register returns the output latch through the same two-stage delay, whatever `pinIn` holds.
- R7: A 0-to-1 change of a pin's synchronised level sets its status bit when rising detection is enabled. A 1-to-0 change sets it when falling detection is enabled. With both enabled either change sets it, and with neither enabled no change does. The bit is set three rising edges after the pin changes.
- R8: A status bit stays set until software writes a one to it. Writing a zero to a status bit has no effect.
- R9: When a new edge event and a software clear of the same status bit happen in the same cycle, the bit stays set.
- R10: `irq` is high exactly when at least one status bit in either bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Byte address of the register |
| busWr | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 64 | Pad input levels |
| pinOut | output | 64 | Output latch values |
| pinOe | output | 64 | Output drive enables |
| irq | output | 1 | Combined edge interrupt |

## Verification
Each result has a fixed latency:
- A register write shows on `pinOut`, on `pinOe` and in read data at the first sample after the edge that performs the write.
- A pin change reaches the level register after two rising edges.
- A pin change reaches the status register and `irq` after three rising edges.

The bench drives inputs on the falling edge and advances a reference model once per rising edge. It compares the model with the read data and the outputs one falling edge later, so each check lands in the cycle where the result is due. The coincident event-and-clear case is scripted to the exact cycle, with the clear written during the cycle whose closing edge records the event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register kinds, in address order (kind index = word address / banks)
  typedef enum logic [2:0] {
    KIND_LEVEL = 3'd0,
    KIND_DIR   = 3'd1,
    KIND_SET   = 3'd2,
    KIND_CLR   = 3'd3,
    KIND_RISE  = 3'd4,
    KIND_FALL  = 3'd5,
    KIND_STAT  = 3'd6,
    KIND_NONE  = 3'd7
  } regKind_e;

  localparam int KIND_COUNT = 7;
  localparam int KIND_W     = 3;

  // Write strobes from the decoder to one bank of the datapath
  typedef struct packed {
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrRise;
    logic wrFall;
    logic wrStat;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
  import gpio_edge_pkg::*;
#(
  parameter int BANK_SEL_W = 1,
  parameter int ADDR_W     = 2 + BANK_SEL_W + KIND_W
) (
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  output wrStrobe_t             strobes,
  output logic [BANK_SEL_W-1:0] bankSel,
  output regKind_e              rdKind
);

  logic [ADDR_W-3:0] wordIdx;
  logic [KIND_W-1:0] kindRaw;
  logic [1:0]        unusedByteLane;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedByteLane = busAddr[1:0];
  assign bankSel        = wordIdx[BANK_SEL_W-1:0];
  assign kindRaw        = wordIdx[ADDR_W-3:BANK_SEL_W];

  always_comb begin
    if (kindRaw < KIND_W'(KIND_COUNT)) rdKind = regKind_e'(kindRaw);
    else                               rdKind = KIND_NONE;
  end

  always_comb begin
    strobes = '0;
    if (busWr) begin
      case (rdKind)
        KIND_DIR:  strobes.wrDir  = 1'b1;
        KIND_SET:  strobes.wrSet  = 1'b1;
        KIND_CLR:  strobes.wrClr  = 1'b1;
        KIND_RISE: strobes.wrRise = 1'b1;
        KIND_FALL: strobes.wrFall = 1'b1;
        KIND_STAT: strobes.wrStat = 1'b1;
        default:   strobes        = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_slice.sv
module gpio_edge_slice
  import gpio_edge_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobe_t         strobes,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] padIn,
  output logic [BANK_W-1:0] outQ,
  output logic [BANK_W-1:0] dirQ,
  output logic [BANK_W-1:0] riseQ,
  output logic [BANK_W-1:0] fallQ,
  output logic [BANK_W-1:0] statQ,
  output logic [BANK_W-1:0] levelQ,
  output logic              anySet
);

  logic [BANK_W-1:0] padSeen;
  logic [BANK_W-1:0] syncA;
  logic [BANK_W-1:0] delayQ;
  logic [BANK_W-1:0] events;
  logic [BANK_W-1:0] clearMask;

  // Output pins observe their own drive, input pins the pad
  assign padSeen = (dirQ & outQ) | (~dirQ & padIn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA  <= '0;
      levelQ <= '0;
      delayQ <= '0;
    end else begin
      syncA  <= padSeen;
      levelQ <= syncA;
      delayQ <= levelQ;
    end
  end

  assign events    = (riseQ & levelQ & ~delayQ) | (fallQ & ~levelQ & delayQ);
  assign clearMask = strobes.wrStat ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outQ  <= '0;
      dirQ  <= '0;
      riseQ <= '0;
      fallQ <= '0;
      statQ <= '0;
    end else begin
      if (strobes.wrDir)  dirQ  <= wdata;
      if (strobes.wrRise) riseQ <= wdata;
      if (strobes.wrFall) fallQ <= wdata;
      if (strobes.wrSet)       outQ <= outQ | wdata;
      else if (strobes.wrClr)  outQ <= outQ & ~wdata;
      // a fresh event outranks a clear of the same bit
      statQ <= (statQ & ~clearMask) | events;
    end
  end

  assign anySet = |statQ;

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 32,
  parameter int BANK_SEL_W = 1,
  localparam int PINS      = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  wrStrobe_t             strobes,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  regKind_e              rdKind,
  input  logic [BANK_W-1:0]     wdata,
  output logic [BANK_W-1:0]     rdata,
  input  logic [PINS-1:0]       pinIn,
  output logic [PINS-1:0]       pinOut,
  output logic [PINS-1:0]       pinOe,
  output logic                  irq
);

  logic [BANK_W-1:0] levelB [NUM_BANKS];
  logic [BANK_W-1:0] dirB   [NUM_BANKS];
  logic [BANK_W-1:0] riseB  [NUM_BANKS];
  logic [BANK_W-1:0] fallB  [NUM_BANKS];
  logic [BANK_W-1:0] statB  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankAny;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wrStrobe_t         bankStrobes;
    logic [BANK_W-1:0] outB;

    assign bankStrobes = (bankSel == BANK_SEL_W'(b)) ? strobes : '0;

    gpio_edge_slice #(.BANK_W(BANK_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobes(bankStrobes),
      .wdata  (wdata),
      .padIn  (pinIn[b*BANK_W +: BANK_W]),
      .outQ   (outB),
      .dirQ   (dirB[b]),
      .riseQ  (riseB[b]),
      .fallQ  (fallB[b]),
      .statQ  (statB[b]),
      .levelQ (levelB[b]),
      .anySet (bankAny[b])
    );

    assign pinOut[b*BANK_W +: BANK_W] = outB;
    assign pinOe[b*BANK_W +: BANK_W]  = dirB[b];
  end

  always_comb begin
    case (rdKind)
      KIND_LEVEL: rdata = levelB[bankSel];
      KIND_DIR:   rdata = dirB[bankSel];
      KIND_RISE:  rdata = riseB[bankSel];
      KIND_FALL:  rdata = fallB[bankSel];
      KIND_STAT:  rdata = statB[bankSel];
      default:    rdata = '0;
    endcase
  end

  assign irq = |bankAny;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = 2 + BANK_SEL_W + KIND_W,
  localparam int PINS       = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irq
);

  wrStrobe_t             strobes;
  logic [BANK_SEL_W-1:0] bankSel;
  regKind_e              rdKind;

  gpio_edge_decode #(.BANK_SEL_W(BANK_SEL_W), .ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr),
    .busWr  (busWr),
    .strobes(strobes),
    .bankSel(bankSel),
    .rdKind (rdKind)
  );

  gpio_edge_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .BANK_SEL_W(BANK_SEL_W)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .bankSel(bankSel),
    .rdKind (rdKind),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6,
  localparam int PINS     = NUM_BANKS * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [BANK_W-1:0] busWdata,
  input logic [BANK_W-1:0] busRdata,
  input logic [PINS-1:0]   pinOut,
  input logic [PINS-1:0]   pinOe,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] DIR0  = ADDR_W'(4 * NUM_BANKS * 1);
  localparam logic [ADDR_W-1:0] SET0  = ADDR_W'(4 * NUM_BANKS * 2);
  localparam logic [ADDR_W-1:0] CLR0  = ADDR_W'(4 * NUM_BANKS * 3);
  localparam logic [ADDR_W-1:0] STAT0 = ADDR_W'(4 * NUM_BANKS * 6);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (pinOut == '0 && pinOe == '0 && !irq));

  // R4
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == DIR0) |=> (pinOe[BANK_W-1:0] == $past(busWdata)));

  // R3
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == SET0) |=>
      ((pinOut[BANK_W-1:0] & $past(busWdata)) == $past(busWdata)));

  // R3
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == CLR0) |=> ((pinOut[BANK_W-1:0] & $past(busWdata)) == '0));

  // R10
  stat_read_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busWr && busAddr == STAT0 && busRdata != '0) |-> irq);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !busWr) |=> irq);

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irq     (irq)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] pinIn = '0;
  logic [63:0] pinOut;
  logic [63:0] pinOe;
  logic        irq;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  // reference state
  logic [63:0] mDir, mLat, mRise, mFall, mStat, mS1, mS2, mDly;
  logic [63:0] curPins = '0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] half(logic [63:0] v, logic b);
    return b ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [31:0] modelRead(logic [5:0] a);
    logic [3:0] w = a[5:2];
    case (w[3:1])
      3'd0: return half(mS2, w[0]);
      3'd1: return half(mDir, w[0]);
      3'd4: return half(mRise, w[0]);
      3'd5: return half(mFall, w[0]);
      3'd6: return half(mStat, w[0]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string kindTag(logic [5:0] a);
    case (a[5:3])
      3'd0: return "R5";
      3'd1: return "R4";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic void modelReset();
    {mDir, mLat, mRise, mFall, mStat, mS1, mS2, mDly} = '0;
  endfunction

  function automatic void modelTick();
    logic [63:0] pad = (mDir & mLat) | (~mDir & pinIn);
    logic [63:0] ev  = (mRise & mS2 & ~mDly) | (mFall & ~mS2 & mDly);
    logic [63:0] wmask = busWdata[0] ? 64'h0 : 64'h0;
    logic [3:0]  w = busAddr[5:2];
    wmask = w[0] ? {busWdata, 32'h0} : {32'h0, busWdata};
    mDly = mS2; mS2 = mS1; mS1 = pad;
    if (busWr) begin
      case (w[3:1])
        3'd1: mDir  = (mDir  & ~(w[0] ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF)) | wmask;
        3'd2: mLat  = mLat | wmask;
        3'd3: mLat  = mLat & ~wmask;
        3'd4: mRise = (mRise & ~(w[0] ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF)) | wmask;
        3'd5: mFall = (mFall & ~(w[0] ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF)) | wmask;
        3'd6: mStat = mStat & ~wmask;
        default: ;
      endcase
    end
    mStat = mStat | ev;
  endfunction

  // one bus cycle: drive at falling edge, check, advance model at rising edge
  task automatic step(logic [5:0] a, logic wr, logic [31:0] d, string tag);
    @(negedge clk);
    busAddr = a; busWr = wr; busWdata = d; pinIn = curPins;
    #1;
    check(tag, {32'h0, busRdata}, {32'h0, modelRead(a)});
    check("R3 pinOut", pinOut, mLat);
    check("R4 pinOe", pinOe, mDir);
    check("R10 irq", {63'h0, irq}, {63'h0, |mStat});
    @(posedge clk);
    modelTick();
  endtask

  task automatic idle(int n, logic [5:0] a, string tag);
    for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int a = 0; a < 16; a++) step(6'(a * 4), 1'b0, 32'h0, "R1");

    // R4: direction holds its value
    step(6'h0C, 1'b1, 32'hA5A5_0F0F, "R4");
    step(6'h0C, 1'b0, 32'h0, "R4");
    step(6'h08, 1'b0, 32'h0, "R4");

    // R3: set, clear, zero write, strobes read zero
    step(6'h10, 1'b1, 32'h0000_00FF, "R3");
    step(6'h18, 1'b1, 32'h0000_000F, "R3");
    step(6'h10, 1'b1, 32'h0000_0000, "R3");
    step(6'h10, 1'b0, 32'h0, "R3");
    step(6'h18, 1'b0, 32'h0, "R3");

    // R6: output pins read back the latch, not the pad
    curPins = 64'h0000_0000_0000_00AA;
    step(6'h08, 1'b1, 32'h0000_00FF, "R6");
    idle(4, 6'h00, "R6");

    // R5: input level after synchroniser, bank 1
    step(6'h0C, 1'b1, 32'h0, "R5");
    curPins = 64'h1234_5678_0000_00AA;
    idle(4, 6'h04, "R5");
    curPins = 64'h8765_4321_0000_00AA;
    idle(3, 6'h04, "R5");
    step(6'h08, 1'b1, 32'h0, "R5");

    // R7: rising on bit16, falling on bit17, both on bit18, none bit19
    step(6'h20, 1'b1, 32'h0005_0000, "R7");
    step(6'h28, 1'b1, 32'h0006_0000, "R7");
    curPins[19:16] = 4'b1111;
    idle(4, 6'h30, "R7");
    curPins[19:16] = 4'b0000;
    idle(4, 6'h30, "R7");

    // R8: writing zero keeps status, writing one clears
    step(6'h30, 1'b1, 32'h0, "R8");
    step(6'h30, 1'b0, 32'h0, "R8");
    step(6'h30, 1'b1, 32'h0002_0000, "R8");
    step(6'h30, 1'b0, 32'h0, "R8");

    // R9: clear lands in the cycle that records a new rising edge on bit16
    curPins[16] = 1'b1;
    step(6'h30, 1'b0, 32'h0, "R9");
    step(6'h30, 1'b0, 32'h0, "R9");
    step(6'h30, 1'b1, 32'h0001_0000, "R9");
    step(6'h30, 1'b0, 32'h0, "R9");
    step(6'h30, 1'b0, 32'h0, "R9");

    // R10: clear all, interrupt drops
    step(6'h30, 1'b1, 32'hFFFF_FFFF, "R10");
    step(6'h34, 1'b1, 32'hFFFF_FFFF, "R10");
    step(6'h30, 1'b0, 32'h0, "R10");

    // R2: unmapped words read zero and disturb nothing
    step(6'h38, 1'b1, 32'hFFFF_FFFF, "R2");
    step(6'h3C, 1'b1, 32'hFFFF_FFFF, "R2");
    step(6'h38, 1'b0, 32'h0, "R2");
    step(6'h3C, 1'b0, 32'h0, "R2");
    for (int a = 0; a < 14; a++) step(6'(a * 4), 1'b0, 32'h0, "R2");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a = 6'($urandom_range(0, 15) * 4);
      logic wr = ($urandom_range(0, 2) == 0);
      curPins = curPins ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      step(a, wr, $urandom, kindTag(a));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule